// File: doc/BRIEF.md
# I2C-Controlled Channel Selector

This block is a small I2C slave that decides which one of eight downstream bus channels is joined to the upstream bus. The bus master addresses it, writes a control byte, and the block turns that byte into a one-hot channel-connect vector. That vector drives the external pass switches, which are not part of this block. The master can also read the control byte back to learn which channel is live.

The slave samples SCL and SDA on a fast system clock through synchronisers. It finds START and STOP from the synchronised samples. It drives SDA only through an open-drain pull-low enable. A newly written selection is held back until the master ends the transaction with STOP, so a channel is never switched in the middle of a transfer. Reset returns the block to the state where only channel 0 is connected.

Top module: `chansel_i2c`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {4'b1110, strap_i[2:0]}. For any other address it does not pull SDA low, the transaction has no effect, and the slave waits for the next START.
- R2: Every data byte of a write transaction is acknowledged. When several bytes are written, only the last one is kept.
- R3: A written selection does not change chan_en_o before the next STOP. After the STOP, chan_en_o changes within a few system clocks.
- R4: Only control bits 3:0 are stored. Bit 3 is the enable and bits 2:0 are the channel number. With bit 3 set, chan_en_o is 1 << bits[2:0]. With bit 3 clear, chan_en_o is all zero. Bits 7:4 have no effect.
- R5: At most one bit of chan_en_o is set at any time.
- R6: Bit 0 of the address byte selects the operation: 1 means read and 0 means write. A read returns {4'b0000, active control bits 3:0}, most significant bit first, and repeats that byte for each byte the master acknowledges. After the master does not acknowledge, the slave leaves SDA released.
- R7: While rst_n is low, and right after it is released, chan_en_o is 8'h01, the control value reads 8'h08, and sda_oe_o is 0.
- R8: The slave pulls SDA low during the ninth SCL clock after a matching address byte and after each written data byte.
- R9: A START received while a byte is in progress abandons that byte and restarts address reception.
- R10: sda_oe_o changes only while SCL is low, so data driven by the slave is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level |
| strap_i | input | 3 | Address strap pins, low bits of the slave address |
| sda_oe_o | output | 1 | 1 pulls the upstream SDA low |
| chan_en_o | output | 8 | One-hot channel connect vector |

## Verification
The bench builds the block with its default parameters: eight channels, three strap bits and a two-stage synchroniser. With these values the full strap-by-address grid of 64 pairs is small enough to sweep completely. For each pair the bench checks whether the address is acknowledged and which channel becomes live after the STOP, computing the expected one-hot value arithmetically. With only four stored control bits, the enable-clear case, ignored upper bits, multi-byte writes, a read inside an open write transaction and an aborted byte can each be set up directly and compared against a value computed in the bench.

// File: rtl/chansel_pkg.sv
package chansel_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK
   } slv_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/chansel_sync.sv
module chansel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("chansel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/chansel_slave.sv
module chansel_slave
   import chansel_pkg::*;
#(
   parameter int           CTRL_W    = 4,
   parameter int           STRAP_W   = 3,
   parameter logic [6:0]   ADDR_BASE = 7'b1110000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_s,
   input  logic               sda_s,
   input  logic [STRAP_W-1:0] strap,
   output logic               sda_oe,
   output logic [CTRL_W-1:0]  ctrl
);
   localparam logic [CTRL_W-1:0] CTRL_RST = {1'b1, {(CTRL_W-1){1'b0}}};

   logic              scl_q, sda_q;
   logic              scl_rise, scl_fall, start_p, stop_p;
   slv_state_e        st;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rw, rx_ack, pend_v, oe_q;
   logic [CTRL_W-1:0] pend, ctrl_q;
   logic [6:0]        my_addr;
   logic [BYTE_W-1:0] rd_byte;

   assign my_addr  = {ADDR_BASE[6:STRAP_W], strap};
   assign rd_byte  = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         st     <= ST_IDLE;
         cnt    <= '0;
         shreg  <= '0;
         rw     <= 1'b0;
         rx_ack <= 1'b0;
         pend_v <= 1'b0;
         pend   <= '0;
         ctrl_q <= CTRL_RST;
         oe_q   <= 1'b0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (start_p) begin
            st   <= ST_ADDR;
            cnt  <= '0;
            oe_q <= 1'b0;
         end else if (stop_p) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            oe_q <= 1'b0;
            if (pend_v) begin
               ctrl_q <= pend;
               pend_v <= 1'b0;
            end
         end else begin
            case (st)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise && cnt < 4'd8) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == my_addr) begin
                           oe_q <= 1'b1;
                           rw   <= shreg[0];
                           st   <= ST_AACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        pend   <= shreg[CTRL_W-1:0];
                        pend_v <= 1'b1;
                        oe_q   <= 1'b1;
                        st     <= ST_WACK;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        shreg <= rd_byte;
                        oe_q  <= ~rd_byte[BYTE_W-1];
                        st    <= ST_RDATA;
                     end else begin
                        oe_q <= 1'b0;
                        st   <= ST_WDATA;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     oe_q <= 1'b0;
                     st   <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        oe_q <= 1'b0;
                        cnt  <= '0;
                        st   <= ST_RACK;
                     end else begin
                        oe_q  <= ~shreg[BYTE_W-2];
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     rx_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (rx_ack) begin
                        shreg <= rd_byte;
                        oe_q  <= ~rd_byte[BYTE_W-1];
                        st    <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = oe_q;
   assign ctrl   = ctrl_q;

   assert_commit_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> $past(stop_p));

   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> !$past(scl_s));

   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !oe_q);

   assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK) |-> !oe_q);
endmodule

// File: rtl/chansel_decode.sv
module chansel_decode #(
   parameter int NUM_CH = 8,
   parameter int SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W:0]   ctrl,
   output logic [NUM_CH-1:0] chan_en
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         assign chan_en[gi] = ctrl[SEL_W] && (ctrl[SEL_W-1:0] == SEL_W'(gi));
      end
   endgenerate

   assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_en));
endmodule

// File: rtl/chansel_i2c.sv
module chansel_i2c #(
   parameter int         NUM_CH      = 8,
   parameter int         STRAP_W     = 3,
   parameter logic [6:0] ADDR_BASE   = 7'b1110000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_oe_o,
   output logic [NUM_CH-1:0]  chan_en_o
);
   localparam int SEL_W  = $clog2(NUM_CH);
   localparam int CTRL_W = SEL_W + 1;

   generate
      if (NUM_CH != (1 << SEL_W) || SEL_W < 1) begin : g_bad_ch
         $error("chansel_i2c: NUM_CH must be a power of two of at least 2");
      end
      if (CTRL_W > 7) begin : g_bad_ctrl
         $error("chansel_i2c: control field must fit below bit 7");
      end
      if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
         $error("chansel_i2c: STRAP_W must be 1 to 6");
      end
   endgenerate

   logic              scl_s, sda_s;
   logic [CTRL_W-1:0] ctrl;

   chansel_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));

   chansel_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

   chansel_slave #(
      .CTRL_W(CTRL_W), .STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)
   ) u_slave (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .strap(strap_i), .sda_oe(sda_oe_o), .ctrl(ctrl));

   chansel_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .chan_en(chan_en_o));
endmodule

// File: tb/chansel_i2c_tb_top.sv
module chansel_i2c_tb_top;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic       sda_oe;
   logic [7:0] chan_en;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_ctrl;

   assign sda_line = sda_m & ~sda_oe;

   always #2.5 clk = ~clk;

   chansel_i2c dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_i(strap), .sda_oe_o(sda_oe), .chan_en_o(chan_en));

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] onehot_of(input logic [3:0] c);
      return c[3] ? (8'd1 << c[2:0]) : 8'd0;
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2 * Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack = ~sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] v);
      logic b1, b2;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(Q);
         scl_m = 1'b1; wq(Q);
         b1 = sda_line; wq(Q);
         b2 = sda_line;
         chk("R10 stable while SCL high", {31'd0, b2}, {31'd0, b1});
         scl_m = 1'b0; wq(Q);
         v[i] = b1;
      end
      sda_m = nack; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_txn(input logic [7:0] d);
      logic a;
      bus_start();
      put_byte({4'b1110, strap, 1'b0}, a);
      chk("R1 address ack", {31'd0, a}, 32'd1);
      put_byte(d, a);
      chk("R8 data ack", {31'd0, a}, 32'd1);
      chk("R3 no change before STOP", {24'd0, chan_en}, {24'd0, onehot_of(exp_ctrl)});
      bus_stop();
      exp_ctrl = d[3:0];
   endtask

   task automatic read_txn(input string req);
      logic a;
      logic [7:0] v;
      bus_start();
      put_byte({4'b1110, strap, 1'b1}, a);
      chk("R8 read address ack", {31'd0, a}, 32'd1);
      get_byte(1'b1, v);
      chk(req, {24'd0, v}, {28'd0, exp_ctrl});
      wq(Q);
      chk("R6 released after NACK", {31'd0, sda_oe}, 32'd0);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] v0, v1;
      exp_ctrl = 4'b1000;
      wq(10);
      chk("R7 reset chan_en", {24'd0, chan_en}, 32'h01);
      chk("R7 reset sda_oe", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      wq(Q);
      chk("R7 chan_en after release", {24'd0, chan_en}, 32'h01);
      read_txn("R7 R6 reset readback");

      // R1 R4: full strap x address sweep
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         wq(Q);
         for (int ad = 0; ad < 8; ad++) begin
            logic [7:0] d;
            d = 8'hA8 | 8'((s + ad + 3) & 7);
            bus_start();
            put_byte({4'b1110, 3'(ad), 1'b0}, a);
            chk("R1 address match", {31'd0, a}, {31'd0, (ad == s)});
            if (a) begin
               put_byte(d, a);
               chk("R8 data ack", {31'd0, a}, 32'd1);
               chk("R3 held before STOP", {24'd0, chan_en}, {24'd0, onehot_of(exp_ctrl)});
               exp_ctrl = d[3:0];
            end
            bus_stop();
            chk("R4 decode after STOP", {24'd0, chan_en}, {24'd0, onehot_of(exp_ctrl)});
         end
      end

      // R2: several bytes, last one kept
      strap = 3'd5; wq(Q);
      bus_start();
      put_byte({4'b1110, strap, 1'b0}, a);
      put_byte(8'h09, a);
      put_byte(8'h0C, a);
      put_byte(8'h0E, a);
      chk("R2 last byte acked", {31'd0, a}, 32'd1);
      chk("R3 held before STOP", {24'd0, chan_en}, {24'd0, onehot_of(exp_ctrl)});
      bus_stop();
      exp_ctrl = 4'hE;
      chk("R2 last byte kept", {24'd0, chan_en}, 32'h40);

      // R4: enable clear, upper bits ignored
      write_txn(8'h05);
      chk("R4 enable clear", {24'd0, chan_en}, 32'h00);
      read_txn("R6 R4 read disabled value");
      write_txn(8'hFF);
      chk("R4 upper bits ignored", {24'd0, chan_en}, 32'h80);
      read_txn("R6 R4 read upper zero");

      // R9: aborted byte then repeated START
      bus_start();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      bus_start();
      put_byte({4'b1110, strap, 1'b0}, a);
      chk("R9 address after repeated START", {31'd0, a}, 32'd1);
      put_byte(8'h0A, a);
      bus_stop();
      exp_ctrl = 4'hA;
      chk("R9 write after restart", {24'd0, chan_en}, 32'h04);

      // R3 R6: read inside open write returns active value
      bus_start();
      put_byte({4'b1110, strap, 1'b0}, a);
      put_byte(8'h0B, a);
      bus_start();
      put_byte({4'b1110, strap, 1'b1}, a);
      get_byte(1'b0, v0);
      get_byte(1'b1, v1);
      chk("R3 read before STOP shows active", {24'd0, v0}, 32'h0A);
      chk("R6 second read byte repeats", {24'd0, v1}, 32'h0A);
      chk("R3 channel held in open txn", {24'd0, chan_en}, 32'h04);
      bus_stop();
      exp_ctrl = 4'hB;
      chk("R3 applied at STOP", {24'd0, chan_en}, 32'h08);

      // R7: reset mid-operation
      rst_n = 1'b0; wq(4);
      chk("R7 reset restores channel 0", {24'd0, chan_en}, 32'h01);
      rst_n = 1'b1; wq(Q);
      exp_ctrl = 4'b1000;
      read_txn("R7 reset readback");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule